// File: doc/BRIEF.md
# Ethernet PHY Bring-Up Sequencer

This block takes an attached Ethernet PHY from power-on to a configured state. It drives a generic management-bus master through a request and acknowledge port. After a start pulse it issues a soft reset to the PHY. It then polls the control register on a millisecond tick until the PHY reports that it has left both reset and power-down. Next it reads the two identifier registers and builds a 32-bit PHY ID from them. It writes the control word fixed by parameters and, when asked, switches the PHY to reduced-pin (RMII) mode.

The block does not serialize bits on the management bus. Each transaction goes out as a one-cycle request carrying the direction, register address and write data. It completes when the master returns an acknowledge, along with read data and a bus-error flag. The sequence ends in one of two sticky states: done, or timeout. A new start pulse leaves either state and runs the sequence again. The millisecond tick comes from a clock divider, so a short period can be used in simulation.

Top module: `phy_bringup_seq`

## Requirements
- R1: A start pulse accepted while not busy makes the first transaction a write to register 0 with data 0x8000. Only bit 15, the soft reset bit, is set.
- R2: Every read of register 0 after the reset write is a poll. Its one-cycle request is high CLKS_PER_MS+1 cycles after the cycle in which the acknowledge of the previous reset write or poll was high.
- R3: A poll counts as complete when bit 15 and bit 11 of the returned data are both 0. If either bit is 1, another poll follows. No other bit of the returned data affects the decision.
- R4: At most MAX_POLLS polls are issued. If the last poll still shows bit 15 or bit 11 set, timeout_o rises and no further transaction is issued.
- R5: If mdio_err_i is high on the acknowledge of the reset write or of any poll, the sequence stops at once, timeout_o rises, and no further transaction is issued.
- R6: After a complete poll, register 2 is read and then register 3. phy_id_o becomes {reg2, reg3 & 0xFFF0}, so the low 4 bits are always 0.
- R7: After the ID reads, register 0 is written with the configuration word. Bit 12 is set when USE_AUTONEG is 1, bit 13 when USE_100M is 1, and bit 8 when USE_FULL_DUPLEX is 1. All other bits are 0.
- R8: rmii_i is sampled with the accepted start pulse. If it was 1, register 0x17 is then written with 0x0020 (bit 5 set) before done. If it was 0, done follows the configuration write directly.
- R9: mdio_req_o is a one-cycle pulse. At most one transaction is outstanding, so no new request is issued until the previous one has been acknowledged.
- R10: After reset, busy_o, done_o, timeout_o, mdio_req_o and phy_id_o are all 0. done_o and timeout_o are mutually exclusive and hold their value until the next accepted start, which clears both in the following cycle.
- R11: A start pulse while busy_o is high is ignored. The transaction sequence and the final result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| rmii_i | input | 1 | Request reduced-pin mode, sampled at start |
| mdio_req_o | output | 1 | One-cycle transaction request |
| mdio_wr_o | output | 1 | 1 = write, 0 = read |
| mdio_addr_o | output | 5 | PHY register address |
| mdio_wdata_o | output | 16 | Write data |
| mdio_ack_i | input | 1 | Transaction complete |
| mdio_err_i | input | 1 | Bus failure, valid with ack |
| mdio_rdata_i | input | 16 | Read data, valid with ack |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sticky: bring-up finished |
| timeout_o | output | 1 | Sticky: bring-up failed |
| phy_id_o | output | 32 | Captured PHY identifier |

## Verification
Because the block has a single state register, a wrong state shows up at the bus port within one transaction. A misplaced state appears as a wrong address, direction or data on the next request, or as an extra or missing request once a terminal state is reached. A fault in the tick divider or the poll budget moves the poll request off its exact cycle, or changes the number of polls before timeout. The bench measures both on every poll. A fault in the ID capture or the configuration word appears in phy_id_o or in the write data as soon as the sequence ends.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RST, ST_WAIT, ST_POLL, ST_ID_HI, ST_ID_LO, ST_CFG, ST_RMII, ST_DONE, ST_FAIL
  } seq_state_e;

  localparam logic [4:0] ADDR_CTRL   = 5'h00;
  localparam logic [4:0] ADDR_ID_HI  = 5'h02;
  localparam logic [4:0] ADDR_ID_LO  = 5'h03;
  localparam logic [4:0] ADDR_IFMODE = 5'h17;

  localparam int BIT_SOFT_RST = 15;
  localparam int BIT_SPD      = 13;
  localparam int BIT_AN       = 12;
  localparam int BIT_PWR_DN   = 11;
  localparam int BIT_FDX      = 8;
  localparam int BIT_RMII     = 5;

  localparam logic [15:0] ID_LO_MASK = 16'hFFF0;

  function automatic logic [15:0] one_hot16(input int pos);
    logic [15:0] w;
    w = '0;
    w[pos] = 1'b1;
    return w;
  endfunction

  function automatic logic [15:0] cfg_word(input bit an, input bit spd, input bit fdx);
    logic [15:0] w;
    w = '0;
    w[BIT_AN]  = an;
    w[BIT_SPD] = spd;
    w[BIT_FDX] = fdx;
    return w;
  endfunction
endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
  parameter int CLKS_PER_MS = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
  parameter int MAX_POLLS = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic use_i,
  output logic last_o
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] FINAL = CW'(MAX_POLLS - 1);

  logic [CW-1:0] used_q;

  // last_o: the poll in flight is the final one allowed
  assign last_o = (used_q == FINAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     used_q <= '0;
    else if (load_i) used_q <= '0;
    else if (use_i)  used_q <= used_q + 1'b1;
  end
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int CLKS_PER_MS     = 100000,
  parameter int MAX_POLLS       = 400,
  parameter bit USE_AUTONEG     = 1'b1,
  parameter bit USE_100M        = 1'b1,
  parameter bit USE_FULL_DUPLEX = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        rmii_i,
  output logic        mdio_req_o,
  output logic        mdio_wr_o,
  output logic [4:0]  mdio_addr_o,
  output logic [15:0] mdio_wdata_o,
  input  logic        mdio_ack_i,
  input  logic        mdio_err_i,
  input  logic [15:0] mdio_rdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        timeout_o,
  output logic [31:0] phy_id_o
);
  localparam logic [15:0] CFG_WORD    = cfg_word(USE_AUTONEG, USE_100M, USE_FULL_DUPLEX);
  localparam logic [15:0] RST_WORD    = one_hot16(BIT_SOFT_RST);
  localparam logic [15:0] IFMODE_WORD = one_hot16(BIT_RMII);

  seq_state_e  state_q, state_d;
  logic        req_q, wr_q, rmii_q;
  logic [4:0]  addr_q;
  logic [15:0] wdata_q, id_hi_q, id_lo_q;

  logic        launch, l_wr, accept, cap_hi, cap_lo, bud_use, bud_last, tick;
  logic [4:0]  l_addr;
  logic [15:0] l_data;
  logic        still_busy;

  ms_tick_gen #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q != ST_WAIT),
    .tick_o(tick)
  );

  poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .use_i (bud_use),
    .last_o(bud_last)
  );

  assign still_busy = mdio_rdata_i[BIT_SOFT_RST] | mdio_rdata_i[BIT_PWR_DN];

  always_comb begin
    state_d = state_q;
    launch  = 1'b0;
    l_wr    = 1'b0;
    l_addr  = ADDR_CTRL;
    l_data  = '0;
    accept  = 1'b0;
    cap_hi  = 1'b0;
    cap_lo  = 1'b0;
    bud_use = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start_i) begin
          accept  = 1'b1;
          launch  = 1'b1;
          l_wr    = 1'b1;
          l_data  = RST_WORD;
          state_d = ST_RST;
        end
      end
      ST_RST: begin
        if (mdio_ack_i) state_d = mdio_err_i ? ST_FAIL : ST_WAIT;
      end
      ST_WAIT: begin
        if (tick) begin
          launch  = 1'b1;
          state_d = ST_POLL;
        end
      end
      ST_POLL: begin
        if (mdio_ack_i) begin
          if (mdio_err_i) begin
            state_d = ST_FAIL;
          end else if (!still_busy) begin
            launch  = 1'b1;
            l_addr  = ADDR_ID_HI;
            state_d = ST_ID_HI;
          end else if (bud_last) begin
            state_d = ST_FAIL;
          end else begin
            bud_use = 1'b1;
            state_d = ST_WAIT;
          end
        end
      end
      ST_ID_HI: begin
        if (mdio_ack_i) begin
          cap_hi  = 1'b1;
          launch  = 1'b1;
          l_addr  = ADDR_ID_LO;
          state_d = ST_ID_LO;
        end
      end
      ST_ID_LO: begin
        if (mdio_ack_i) begin
          cap_lo  = 1'b1;
          launch  = 1'b1;
          l_wr    = 1'b1;
          l_data  = CFG_WORD;
          state_d = ST_CFG;
        end
      end
      ST_CFG: begin
        if (mdio_ack_i) begin
          if (rmii_q) begin
            launch  = 1'b1;
            l_wr    = 1'b1;
            l_addr  = ADDR_IFMODE;
            l_data  = IFMODE_WORD;
            state_d = ST_RMII;
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      ST_RMII: begin
        if (mdio_ack_i) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rmii_q  <= 1'b0;
      id_hi_q <= '0;
      id_lo_q <= '0;
    end else begin
      state_q <= state_d;
      req_q   <= launch;
      if (launch) begin
        wr_q    <= l_wr;
        addr_q  <= l_addr;
        wdata_q <= l_data;
      end
      if (accept) begin
        rmii_q  <= rmii_i;
        id_hi_q <= '0;
        id_lo_q <= '0;
      end
      if (cap_hi) id_hi_q <= mdio_rdata_i;
      if (cap_lo) id_lo_q <= mdio_rdata_i & ID_LO_MASK;
    end
  end

  assign mdio_req_o   = req_q;
  assign mdio_wr_o    = wr_q;
  assign mdio_addr_o  = addr_q;
  assign mdio_wdata_o = wdata_q;
  assign done_o       = (state_q == ST_DONE);
  assign timeout_o    = (state_q == ST_FAIL);
  assign busy_o       = !(state_q inside {ST_IDLE, ST_DONE, ST_FAIL});
  assign phy_id_o     = {id_hi_q, id_lo_q};
endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        mdio_req_o,
  input logic        mdio_wr_o,
  input logic [4:0]  mdio_addr_o,
  input logic [15:0] mdio_wdata_o,
  input logic        mdio_ack_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        timeout_o
);
  logic outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         outst_q <= 1'b0;
    else if (mdio_req_o) outst_q <= 1'b1;
    else if (mdio_ack_i) outst_q <= 1'b0;
  end

  p_reset_write_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> mdio_req_o && mdio_wr_o && mdio_addr_o == 5'h00 && mdio_wdata_o == 16'h8000);

  p_terminal_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || timeout_o) && !start_i |=> !mdio_req_o);

  p_ifmode_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_req_o && mdio_wr_o && mdio_addr_o == 5'h17 |-> mdio_wdata_o == 16'h0020);

  p_req_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_req_o |=> !mdio_req_o);

  p_single_outstanding_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_req_o |-> !outst_q);

  p_done_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  p_timeout_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o && !start_i |=> timeout_o);

  p_start_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && !done_o && !timeout_o);
endmodule

bind phy_bringup_seq phy_bringup_seq_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mdio_req_o  (mdio_req_o),
  .mdio_wr_o   (mdio_wr_o),
  .mdio_addr_o (mdio_addr_o),
  .mdio_wdata_o(mdio_wdata_o),
  .mdio_ack_i  (mdio_ack_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .timeout_o   (timeout_o)
);

// File: tb/phy_bringup_seq_tb_top.sv
module phy_bringup_seq_tb_top;
  localparam int  N    = 4;
  localparam int  MAXP = 5;
  localparam bit  AN   = 1'b1;
  localparam bit  SPD  = 1'b0;
  localparam bit  FDX  = 1'b1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, rmii_i = 1'b0;
  logic        req, wr, ack = 1'b0, err = 1'b0;
  logic [4:0]  addr;
  logic [15:0] wdata, rdata = '0;
  logic        busy, done, tmo;
  logic [31:0] phy_id;

  always #5 clk = ~clk;

  phy_bringup_seq #(.CLKS_PER_MS(N), .MAX_POLLS(MAXP), .USE_AUTONEG(AN),
                    .USE_100M(SPD), .USE_FULL_DUPLEX(FDX)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .rmii_i(rmii_i),
    .mdio_req_o(req), .mdio_wr_o(wr), .mdio_addr_o(addr), .mdio_wdata_o(wdata),
    .mdio_ack_i(ack), .mdio_err_i(err), .mdio_rdata_i(rdata),
    .busy_o(busy), .done_o(done), .timeout_o(tmo), .phy_id_o(phy_id));

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // PHY model configuration and log
  int          m_busy_n, m_err_op, m_lat, n_ops, poll_idx, ack_cyc;
  int          timing_bad, overlap_bad, pulse_bad;
  logic [15:0] m_bmask, m_id1, m_id2;
  logic        op_wr [32];
  logic [4:0]  op_addr [32];
  logic [15:0] op_data [32];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic responder();
    bit pending = 0, prev_req = 0;
    int lat_cnt = 0, cur = 0;
    forever begin
      @(negedge clk);
      ack = 1'b0; err = 1'b0;
      if (req && prev_req) pulse_bad++;
      prev_req = req;
      if (pending) begin
        if (req) overlap_bad++;
        if (lat_cnt == 0) begin
          pending = 0;
          ack = 1'b1;
          err = (cur == m_err_op);
          ack_cyc = cyc;
          rdata = '0;
          if (!op_wr[cur]) begin
            if (op_addr[cur] == 5'h00) begin
              rdata = (poll_idx < m_busy_n) ? m_bmask : 16'h3100;
              poll_idx++;
            end else if (op_addr[cur] == 5'h02) rdata = m_id1;
            else if (op_addr[cur] == 5'h03) rdata = m_id2;
          end
        end else lat_cnt--;
      end else if (req) begin
        if (n_ops < 32) begin
          op_wr[n_ops] = wr; op_addr[n_ops] = addr; op_data[n_ops] = wdata;
        end
        if (!wr && addr == 5'h00 && (cyc - ack_cyc) != N + 1) timing_bad++;
        cur = n_ops;
        n_ops++;
        pending = 1;
        lat_cnt = m_lat - 1;
      end
    end
  endtask

  task automatic run(input int busy_n, input logic [15:0] bmask, input int err_op,
                     input bit rmii, input int lat, input bit poke);
    int w, polls, need, total, k;
    bit fail;
    logic [15:0] cfg;
    m_busy_n = busy_n; m_bmask = bmask; m_err_op = err_op; m_lat = lat;
    m_id1 = 16'h2000 + 16'(busy_n * 7 + lat);
    m_id2 = 16'h5C90 | 16'(1 + busy_n);
    n_ops = 0; poll_idx = 0; timing_bad = 0; overlap_bad = 0; pulse_bad = 0;
    @(negedge clk);
    rmii_i = rmii; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; rmii_i = ~rmii;
    chk(busy && !done && !tmo, "R10 start clears flags", {busy, done, tmo}, 3'b100);
    if (poke) begin
      repeat (2) @(negedge clk);
      chk(busy, "R11 busy during stray start", busy, 1);
      start_i = 1'b1; rmii_i = ~rmii;
      @(negedge clk);
      start_i = 1'b0;
    end
    w = 0;
    while (!(done || tmo) && w < 5000) begin @(negedge clk); w++; end
    repeat (3 * N + 10) @(negedge clk);

    if (err_op == 0) begin polls = 0; fail = 1; end
    else begin
      need = (busy_n < MAXP) ? busy_n + 1 : MAXP;
      if (err_op >= 1 && err_op <= need) begin polls = err_op; fail = 1; end
      else begin polls = need; fail = (busy_n >= MAXP); end
    end
    total = 1 + polls + (fail ? 0 : 3 + int'(rmii));
    cfg = (AN ? 16'h1000 : 16'h0) | (SPD ? 16'h2000 : 16'h0) | (FDX ? 16'h0100 : 16'h0);

    chk(n_ops == total, poke ? "R11 op count with stray start" : "R4 R5 op count", n_ops, total);
    chk(op_wr[0] && op_addr[0] == 5'h00 && op_data[0] == 16'h8000, "R1 reset write",
        {op_wr[0], op_addr[0], op_data[0]}, {1'b1, 5'h00, 16'h8000});
    if (n_ops == total) begin
      for (int i = 1; i <= polls; i++)
        chk(!op_wr[i] && op_addr[i] == 5'h00, "R3 poll read of reg 0", {op_wr[i], op_addr[i]}, 6'h00);
      if (!fail) begin
        k = polls + 1;
        chk(!op_wr[k] && op_addr[k] == 5'h02, "R6 id high read", {op_wr[k], op_addr[k]}, 6'h02);
        chk(!op_wr[k+1] && op_addr[k+1] == 5'h03, "R6 id low read", {op_wr[k+1], op_addr[k+1]}, 6'h03);
        chk(op_wr[k+2] && op_addr[k+2] == 5'h00 && op_data[k+2] == cfg, "R7 config write",
            {op_wr[k+2], op_addr[k+2], op_data[k+2]}, {1'b1, 5'h00, cfg});
        if (rmii)
          chk(op_wr[k+3] && op_addr[k+3] == 5'h17 && op_data[k+3] == 16'h0020, "R8 rmii write",
              {op_wr[k+3], op_addr[k+3], op_data[k+3]}, {1'b1, 5'h17, 16'h0020});
        chk(phy_id == {m_id1, m_id2 & 16'hFFF0}, "R6 phy id", phy_id, {m_id1, m_id2 & 16'hFFF0});
      end
    end
    chk(done == !fail && tmo == fail && !busy, fail ? "R4 R5 timeout flag" : "R8 done flag",
        {done, tmo, busy}, {!fail, fail, 1'b0});
    chk(timing_bad == 0, "R2 poll spacing", timing_bad, 0);
    chk(overlap_bad == 0 && pulse_bad == 0, "R9 one outstanding pulse", {overlap_bad[15:0], pulse_bad[15:0]}, 0);
  endtask

  initial begin
    ack_cyc = 0; n_ops = 0; m_err_op = -1; m_lat = 1;
    fork
      responder();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    join_none
    repeat (3) @(negedge clk);
    chk(!req && !busy && !done && !tmo && phy_id == 0, "R10 reset state",
        {req, busy, done, tmo, phy_id}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req && !busy && !done && !tmo, "R10 idle after reset", {req, busy, done, tmo}, 0);
    for (int b = 0; b <= MAXP + 1; b++)
      for (int m = 0; m < 3; m++)
        for (int r = 0; r < 2; r++)
          run(b, (m == 0) ? 16'h8000 : (m == 1) ? 16'h0800 : 16'h8800, -1, r[0],
              1 + ((b + m + r) % 3), (b == 2 && m == 0));
    run(3, 16'h8000, 0, 1'b0, 1, 1'b0);  // R5 error on reset write
    run(3, 16'h8000, 1, 1'b1, 2, 1'b0);  // R5 error on first poll
    run(1, 16'h0800, 2, 1'b1, 1, 1'b0);  // R5 error on final poll
    run(4, 16'h8800, 3, 1'b0, 3, 1'b0);
    run(0, 16'h8000, -1, 1'b1, 2, 1'b0); // R10 restart after timeout
    finish_run();
  end
endmodule